// File: doc/BRIEF.md
# Receive Word Aligner with Requested Realignment

This block sits behind a deserializer whose parallel words can start on any bit. Each clock it joins the newest 10-bit word with the one before it. It checks every one of the ten possible bit offsets in that 20-bit span against a programmable alignment pattern. The pattern can be 7 or 10 bits long. Both the pattern and its bitwise inverse count as a match.

A fabric-side request controls when the block may move its word boundary. A build-time mode selects how that request is read.

- **Level mode:** while the request is high, the aligner may take any offset where the pattern turns up. The sync flag pulses for one clock when the aligner moves to a different boundary.
- **Edge mode:** only a rising edge of the request starts a search, and the aligner locks on the first match after that edge. The sync flag then stays high until the next rising edge of the request clears it.

The block always outputs the realigned word together with a one-clock pattern-detect flag for that word.

Top module: `rx_word_aligner`

## Requirements
- R1: While reset is low, after each clock `word_out`, `pattern_det` and `sync_status` are all zero, and the selected offset returns to 0.
- R2: The candidate at offset k (0..9) is bits k to k+9 of the 20-bit value {current word, previous word}. Bit 0 is the oldest received bit. When several offsets match in the same cycle, the lowest offset is taken.
- R3: When `short_pattern` is 1, only bits 6:0 of a candidate and of `align_pattern` are compared. When it is 0, all 10 bits are compared.
- R4: A candidate matches if its compared bits equal those of `align_pattern` or equal those of the pattern's bitwise inverse.
- R5: In level mode, a match in a cycle with `align_req` high selects the lowest matching offset. `sync_status` is then high for exactly the next clock if that offset differs from the held one, or if no alignment has happened since reset.
- R6: In level mode with `align_req` low, matches do not change the offset. `word_out` keeps using the held offset.
- R7: In edge mode, a rising edge of `align_req` (sampled high, was low on the previous clock) arms a search. The first match in the cycle of that edge or later selects the offset and disarms the search. While the request stays high afterwards, later matches do not move the offset.
- R8: In edge mode, `sync_status` rises when the armed search finds a match. It stays high after that. It falls at the first rising edge of `align_req` that does not find a match in the same cycle, and stays low until a match is found.
- R9: `pattern_det` is high for a clock exactly when the word just placed on `word_out` is a match (using R3 and R4). This includes words after lock.
- R10: `word_out` is registered. It equals the candidate at the offset in force for that input cycle, and a newly selected offset already applies to the cycle that found it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel word clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_data | input | 10 | Unaligned word from the deserializer, bit 0 received first |
| align_pattern | input | 10 | Pattern to search for |
| short_pattern | input | 1 | 1: compare 7 bits, 0: compare 10 bits |
| align_req | input | 1 | Realignment request from the fabric |
| word_out | output | 10 | Realigned word |
| pattern_det | output | 1 | Output word holds the pattern or its inverse |
| sync_status | output | 1 | Boundary-change pulse (level mode) or lock flag (edge mode) |

## Verification
All three outputs are registered, so each reflects the inputs sampled at the preceding rising edge and is valid one clock after that edge. The bench changes inputs on the falling edge and updates its reference at the rising edge. It compares outputs at the next falling edge, so every result is checked exactly one clock after the stimulus that caused it. Level-mode and edge-mode instances receive the same stream, which shows how the two handle the request differently.

// File: rtl/rxwa_pkg.sv
// Shared definitions for the receive word aligner.
// Assumes: word widths up to 32 bits; the offset counter is sized by $clog2.
package rxwa_pkg;
    typedef enum logic {
        REQ_LEVEL = 1'b0,
        REQ_EDGE  = 1'b1
    } req_mode_e;

    localparam int DEF_WORD_W    = 10;
    localparam int DEF_SHORT_LEN = 7;
endpackage

// File: rtl/rxwa_window.sv
// Holds the previous word, builds the two-word window and flags every
// offset whose candidate word matches the pattern or its inverse.
// Assumes: SHORT_LEN < W; bit 0 of each word is the oldest received bit.
module rxwa_window #(
    parameter int W         = 10,
    parameter int SHORT_LEN = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     rx_data,
    input  logic [W-1:0]     align_pattern,
    input  logic             short_pattern,
    output logic [2*W-1:0]   window,
    output logic [W-1:0]     hit
);
    localparam logic [W-1:0] SHORT_MASK = {{(W-SHORT_LEN){1'b0}}, {SHORT_LEN{1'b1}}};

    logic [W-1:0] prev_q;
    logic [W-1:0] cmp_mask;

    // Keep the word received one clock earlier.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= rx_data;
    end

    assign window   = {rx_data, prev_q};
    assign cmp_mask = short_pattern ? SHORT_MASK : {W{1'b1}};

    // One comparator per bit offset, true or inverted pattern.
    for (genvar k = 0; k < W; k++) begin : g_cand
        logic [W-1:0] cand;
        assign cand   = window[k +: W];
        assign hit[k] = (((cand ^ align_pattern)  & cmp_mask) == '0) ||
                        (((cand ^ ~align_pattern) & cmp_mask) == '0);
    end
endmodule

// File: rtl/rxwa_ctrl.sv
// Decides when the boundary may move, holds the selected offset and
// drives the sync flag in the behaviour picked by REQ_MODE.
// Assumes: hit is combinational from the current window; lowest offset wins.
module rxwa_ctrl
    import rxwa_pkg::*;
#(
    parameter int        W        = 10,
    parameter int        OFF_W    = 4,
    parameter req_mode_e REQ_MODE = REQ_LEVEL
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             align_req,
    input  logic [W-1:0]     hit,
    output logic [OFF_W-1:0] off_sel,
    output logic             sync_status
);
    logic [OFF_W-1:0] first_off;
    logic [OFF_W-1:0] offset_q;
    logic             any_hit;
    logic             accept;
    logic             sync_q;

    // Priority encode: lowest matching offset.
    always_comb begin
        first_off = '0;
        for (int k = W - 1; k >= 0; k--) begin
            if (hit[k]) first_off = OFF_W'(k);
        end
    end

    assign any_hit = |hit;
    assign off_sel = accept ? first_off : offset_q;

    // Hold the selected boundary until a new alignment is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)      offset_q <= '0;
        else if (accept) offset_q <= first_off;
    end

    if (REQ_MODE == REQ_EDGE) begin : g_edge
        logic req_q;
        logic armed_q;
        logic rise;

        assign rise   = align_req & ~req_q;
        assign accept = (armed_q | rise) & any_hit;

        // Remember the request level for edge detection.
        always_ff @(posedge clk) begin
            if (!rst_n) req_q <= 1'b0;
            else        req_q <= align_req;
        end

        // Arm on a rising edge, lock and set sync on the first match.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                armed_q <= 1'b0;
                sync_q  <= 1'b0;
            end else if (accept) begin
                armed_q <= 1'b0;
                sync_q  <= 1'b1;
            end else if (rise) begin
                armed_q <= 1'b1;
                sync_q  <= 1'b0;
            end
        end
    end else begin : g_level
        logic aligned_q;

        assign accept = align_req & any_hit;

        // Pulse sync for one clock on a move to a new boundary.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                aligned_q <= 1'b0;
                sync_q    <= 1'b0;
            end else begin
                aligned_q <= aligned_q | accept;
                sync_q    <= accept & ((first_off != offset_q) | ~aligned_q);
            end
        end
    end

    assign sync_status = sync_q;
endmodule

// File: rtl/rxwa_shift.sv
// Barrel-shifts the window by the selected offset and registers the
// realigned word together with its pattern-detect flag.
// Assumes: off_sel < W; hit is indexed by the same offsets as the window.
module rxwa_shift #(
    parameter int W     = 10,
    parameter int OFF_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2*W-1:0]   window,
    input  logic [W-1:0]     hit,
    input  logic [OFF_W-1:0] off_sel,
    output logic [W-1:0]     word_out,
    output logic             pattern_det
);
    // Register the aligned word and whether it matched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_out    <= '0;
            pattern_det <= 1'b0;
        end else begin
            word_out    <= window[off_sel +: W];
            pattern_det <= hit[off_sel];
        end
    end
endmodule

// File: rtl/rx_word_aligner.sv
// Top of the receive word aligner: window and match search, alignment
// control and registered output shift.
// Assumes: rx_data is one deserialized word per clock, oldest bit in bit 0.
module rx_word_aligner
    import rxwa_pkg::*;
#(
    parameter int        WORD_W    = DEF_WORD_W,
    parameter int        SHORT_LEN = DEF_SHORT_LEN,
    parameter req_mode_e REQ_MODE  = REQ_LEVEL
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] rx_data,
    input  logic [WORD_W-1:0] align_pattern,
    input  logic              short_pattern,
    input  logic              align_req,
    output logic [WORD_W-1:0] word_out,
    output logic              pattern_det,
    output logic              sync_status
);
    localparam int OFF_W = $clog2(WORD_W);

    logic [2*WORD_W-1:0] window;
    logic [WORD_W-1:0]   hit;
    logic [OFF_W-1:0]    off_sel;

    rxwa_window #(.W(WORD_W), .SHORT_LEN(SHORT_LEN)) u_window (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_data       (rx_data),
        .align_pattern (align_pattern),
        .short_pattern (short_pattern),
        .window        (window),
        .hit           (hit)
    );

    rxwa_ctrl #(.W(WORD_W), .OFF_W(OFF_W), .REQ_MODE(REQ_MODE)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .align_req   (align_req),
        .hit         (hit),
        .off_sel     (off_sel),
        .sync_status (sync_status)
    );

    rxwa_shift #(.W(WORD_W), .OFF_W(OFF_W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .window      (window),
        .hit         (hit),
        .off_sel     (off_sel),
        .word_out    (word_out),
        .pattern_det (pattern_det)
    );
endmodule

// File: rtl/rx_word_aligner_chk.sv
// Checker for the receive word aligner, attached by bind.
// Assumes: ports observed at the top level only.
module rx_word_aligner_chk
    import rxwa_pkg::*;
#(
    parameter req_mode_e REQ_MODE = REQ_LEVEL
) (
    input logic clk,
    input logic rst_n,
    input logic align_req,
    input logic pattern_det,
    input logic sync_status
);
    logic req_d;
    logic rise_w;

    // Own copy of the request history for edge relations.
    always_ff @(posedge clk) begin
        if (!rst_n) req_d <= 1'b0;
        else        req_d <= align_req;
    end
    assign rise_w = align_req & ~req_d;

    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!sync_status && !pattern_det));

    a_r9_sync_with_detect: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_status) |-> pattern_det);

    if (REQ_MODE == REQ_EDGE) begin : g_edge_chk
        a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (sync_status && !rise_w) |=> sync_status);

        a_r8_drop_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(sync_status) |-> $past(rise_w));
    end else begin : g_level_chk
        a_r5_pulse_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
            sync_status |-> $past(align_req));
    end
endmodule

bind rx_word_aligner rx_word_aligner_chk #(.REQ_MODE(REQ_MODE)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .align_req   (align_req),
    .pattern_det (pattern_det),
    .sync_status (sync_status)
);

// File: tb/rx_word_aligner_test.sv
`timescale 1ns/1ps
module rx_word_aligner_test;
    import rxwa_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] din = '0;
    logic [9:0] pattern = 10'h17C;
    logic       pat_short = 1'b0;
    logic       align = 1'b0;

    logic [9:0] wo  [2];
    logic       pd  [2];
    logic       ss  [2];

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit started = 0;
    bit done = 0;

    always #2 clk = ~clk;

    rx_word_aligner #(.REQ_MODE(REQ_LEVEL)) uut (
        .clk(clk), .rst_n(rst_n), .rx_data(din), .align_pattern(pattern),
        .short_pattern(pat_short), .align_req(align),
        .word_out(wo[0]), .pattern_det(pd[0]), .sync_status(ss[0]));

    rx_word_aligner #(.REQ_MODE(REQ_EDGE)) uut_edge (
        .clk(clk), .rst_n(rst_n), .rx_data(din), .align_pattern(pattern),
        .short_pattern(pat_short), .align_req(align),
        .word_out(wo[1]), .pattern_det(pd[1]), .sync_status(ss[1]));

    // Reference state, index 0 = level mode, 1 = edge mode.
    logic [9:0] m_prev [2];
    int         m_off  [2];
    bit         m_aligned [2];
    bit         m_armed [2];
    bit         m_reqd [2];
    bit         m_sync [2];
    logic [9:0] e_word [2];
    bit         e_det  [2];

    function automatic bit is_match(input logic [9:0] c);
        logic [9:0] msk;
        msk = pat_short ? 10'h07F : 10'h3FF;
        return (((c ^ pattern) & msk) == 0) || (((c ^ ~pattern) & msk) == 0);
    endfunction

    task automatic model_step(input int m);
        logic [19:0] win;
        logic [9:0]  c;
        int          first;
        bit          rise;
        bit          acc;
        int          noff;
        if (!rst_n) begin
            m_prev[m] = '0; m_off[m] = 0; m_aligned[m] = 0; m_armed[m] = 0;
            m_reqd[m] = 0; m_sync[m] = 0; e_word[m] = '0; e_det[m] = 0;
            return;
        end
        win = {din, m_prev[m]};
        first = -1;
        for (int k = 9; k >= 0; k--) begin
            c = 10'(win >> k);
            if (is_match(c)) first = k;
        end
        rise = align && !m_reqd[m];
        if (m == 0) acc = align && (first >= 0);
        else        acc = (m_armed[m] || rise) && (first >= 0);
        noff = acc ? first : m_off[m];
        c = 10'(win >> noff);
        e_word[m] = c;
        e_det[m]  = is_match(c);
        if (m == 0) begin
            m_sync[m] = acc && ((first != m_off[m]) || !m_aligned[m]);
        end else begin
            if (acc)       begin m_sync[m] = 1; m_armed[m] = 0; end
            else if (rise) begin m_sync[m] = 0; m_armed[m] = 1; end
        end
        m_aligned[m] = m_aligned[m] || acc;
        m_off[m]  = noff;
        m_reqd[m] = align;
        m_prev[m] = din;
    endtask

    // Advance the reference at every rising edge.
    always @(posedge clk) begin
        model_step(0);
        model_step(1);
        started <= 1;
    end

    task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Compare both instances against the reference on every falling edge.
    always @(negedge clk) begin
        if (started && !done) begin
            check("R2 R6 R10 word_out level", wo[0], e_word[0]);
            check("R2 R7 R10 word_out edge",  wo[1], e_word[1]);
            check("R3 R4 R9 pattern_det level", {9'd0, pd[0]}, {9'd0, e_det[0]});
            check("R3 R4 R9 pattern_det edge",  {9'd0, pd[1]}, {9'd0, e_det[1]});
            check("R5 sync level", {9'd0, ss[0]}, {9'd0, m_sync[0]});
            check("R7 R8 sync edge", {9'd0, ss[1]}, {9'd0, m_sync[1]});
        end
    end

    task automatic summary;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected<=50000", cyc);
            summary();
        end
    end

    logic bq[$];

    task automatic push_noise(input int n);
        for (int i = 0; i < n; i++) bq.push_back(1'($urandom_range(0, 1)));
    endtask

    task automatic push_pat(input bit inv);
        logic [9:0] p;
        int len;
        p = inv ? ~pattern : pattern;
        len = pat_short ? 7 : 10;
        for (int i = 0; i < len; i++) bq.push_back(p[i]);
    endtask

    task automatic flush_words;
        while (bq.size() >= 10) begin
            logic [9:0] w;
            for (int i = 0; i < 10; i++) w[i] = bq.pop_front();
            @(negedge clk);
            din = w;
        end
    endtask

    task automatic bursts(input int n);
        for (int i = 0; i < n; i++) begin
            push_noise($urandom_range(3, 40));
            push_pat(1'($urandom_range(0, 1)));
            push_noise($urandom_range(0, 30));
            flush_words();
        end
    endtask

    task automatic reset_check;
        for (int m = 0; m < 2; m++) begin
            check("R1 reset word_out", wo[m], 10'h000);
            check("R1 reset pattern_det", {9'd0, pd[m]}, 10'h000);
            check("R1 reset sync", {9'd0, ss[m]}, 10'h000);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        reset_check();
        rst_n = 1'b1;

        // Request low: no alignment in either mode.
        align = 1'b0;
        bursts(20);
        // Level request high: free realignment.
        align = 1'b1;
        bursts(40);
        // Request low again: held offset.
        align = 1'b0;
        bursts(20);
        // Short pattern, request toggling.
        pat_short = 1'b1;
        for (int r = 0; r < 30; r++) begin
            align = 1'b1;
            bursts(2);
            align = 1'b0;
            bursts(2);
        end
        // Full pattern with single-cycle request pulses.
        pat_short = 1'b0;
        for (int r = 0; r < 40; r++) begin
            @(negedge clk);
            align = 1'b1;
            @(negedge clk);
            align = 1'b0;
            bursts(2);
        end
        // Mid-run reset clears offset and flags.
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        reset_check();
        rst_n = 1'b1;
        align = 1'b1;
        bursts(30);
        pattern = 10'h283;
        bursts(30);
        align = 1'b0;
        bursts(10);
        repeat (4) @(negedge clk);
        summary();
    end
endmodule